// File: doc/BRIEF.md
# SDRAM Command and Address Controller

The controller converts single host memory requests into SDRAM command cycles on one or two chip-select spaces. It owns the command lines (row strobe, column strobe, write enable), the multiplexed address and bank lines, four active-low byte masks, the clock enable and two chip selects. Each host request becomes a closed-page access. The controller activates the row, then issues one read or write of burst length 1. It then either lets the device auto-precharge or issues an explicit single-bank precharge.

Row width, column width, bank count, data-bus width and the number of SDRAM spaces are set by static configuration inputs, so one netlist serves several device geometries. The activate-to-command, precharge and refresh-cycle delays are also configuration inputs. So is the CAS latency. After reset the controller runs its power-up sequence. It interleaves periodic refreshes with host traffic and can park the devices in self-refresh on request.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: After reset the controller issues precharge-all, auto-refresh, auto-refresh and mode-register write, in that order. The gaps between them are cfg_trp, cfg_trfc and cfg_trfc cycles. req_ready stays low until the cycle after the mode-register write.
- R2: The mode-register write carries the following address value: bits 2:0 = 000 (burst length 1), bit 3 = 0, bits 6:4 = cfg_cl, bit 9 = 1 when cfg_burst_write = 0 (burst read, single write) and 0 when cfg_burst_write = 1 (burst read, burst write). All other address bits and the bank lines are 0.
- R3: Commands are encoded as {ras_n,cas_n,we_n}: 111 no-op, 011 activate, 101 read, 100 write, 010 precharge (address bit 10 high = all banks, low = bank on sd_ba), 001 refresh with clock enable high, 001 with clock enable falling = self-refresh entry, 000 mode-register write. Every command other than no-op has at least one chip select low, and a no-op deselects both.
- R4: The host byte address is split from bit 0 upward into fields in this order: lane offset (2 bits when cfg_wide = 1, 1 bit when 0), column (8/9/10 bits for cfg_col_code 0/1/2), bank (2 bits when cfg_four_banks = 1, 1 bit when 0), then row (11/12/13 bits for cfg_row_code 0/1/2). Code 3 behaves as code 2.
- R5: The activate cycle drives the row on sd_addr and the bank on sd_ba. The read or write cycle drives the column on sd_addr[9:0], req_autopre on sd_addr[10], zeros on sd_addr[12:11], and the same bank.
- R6: Byte masks (sd_dqm_n[i] low = lane i, which is host byte offset i, is accessed) are low only during read/write cycles. With a 32-bit bus, size 0 (byte) enables the lane addressed by addr[1:0], size 1 (half) enables lanes 1:0 or 3:2 by addr[1], and size 2 or 3 enables all lanes. With a 16-bit bus, size 0 enables lane addr[0], any other size enables lanes 1:0, and lanes 3:2 stay masked.
- R7: With cfg_two_spaces = 1, req_addr[31] = 0 selects sd_cs2_n and 1 selects sd_cs3_n. With cfg_two_spaces = 0, every access uses sd_cs3_n and sd_cs2_n stays high. Precharge-all, refresh, self-refresh and mode-register commands assert every configured chip select.
- R8: The activate-to-read/write gap is cfg_trcd cycles. The gap from read/write to explicit precharge is cfg_cl for reads and 1 for writes. A request is accepted at the earliest cfg_trp cycles after a precharge. A wait value of 0 acts as 1.
- R9: An access without auto-precharge is followed by a single-bank precharge (address bit 10 low) to the accessed bank.
- R10: rd_valid is high exactly cfg_cl cycles after a read command.
- R11: Every REF_PERIOD cycles a refresh becomes pending. The controller issues precharge-all and, cfg_trp cycles later, auto-refresh before it accepts any further request.
- R12: While idle with sleep_req high, the controller issues precharge-all and then self-refresh entry (clock enable goes low). Clock enable stays low and no request is accepted while sleep_req stays high. Clock enable returns high the cycle after sleep_req falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_row_code | input | 2 | Row width code: 0=11, 1=12, 2/3=13 bits |
| cfg_col_code | input | 2 | Column width code: 0=8, 1=9, 2/3=10 bits |
| cfg_four_banks | input | 1 | 1 = four banks, 0 = two banks |
| cfg_wide | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| cfg_two_spaces | input | 1 | 1 = both chip-select spaces hold SDRAM |
| cfg_burst_write | input | 1 | 1 = burst write mode, 0 = single write mode |
| cfg_trcd | input | WAIT_W | Activate-to-command wait |
| cfg_trp | input | WAIT_W | Precharge wait |
| cfg_trfc | input | WAIT_W | Refresh cycle wait |
| cfg_cl | input | 3 | CAS latency |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Use auto-precharge for this access |
| req_size | input | 2 | 0 byte, 1 half, 2/3 word |
| req_addr | input | 32 | Host byte address |
| sleep_req | input | 1 | Request self-refresh |
| req_ready | output | 1 | Request is accepted at the next edge if valid |
| rd_valid | output | 1 | Read data is on the SDRAM bus this cycle |
| sd_cke | output | 1 | Clock enable |
| sd_cs2_n | output | 1 | Chip select, first space |
| sd_cs3_n | output | 1 | Chip select, second space |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | 13 | Multiplexed address |
| sd_ba | output | 2 | Bank address |
| sd_dqm_n | output | 4 | Byte masks, active low |

## Verification
The assertions watch several cycle-local rules on every cycle. Any real command has a chip select low. The first select stays idle in single-space mode. Byte masks open only on read/write cycles. Read/write cycles leave address bits 12:11 at zero, and mode-register writes carry burst length 1 and the configured latency. Self-refresh entry uses the refresh encoding, and no request is accepted while the clock enable is low. Only the bench scenarios show the properties that span many cycles or depend on the host address. These are the power-up order and its gaps, and the field split for each geometry. They also cover the activate-to-command and precharge spacing, rd_valid timing, the refresh cadence and the self-refresh hold and exit.

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl #(
  parameter int REF_PERIOD = 512,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_row_code,
  input  logic [1:0]        cfg_col_code,
  input  logic              cfg_four_banks,
  input  logic              cfg_wide,
  input  logic              cfg_two_spaces,
  input  logic              cfg_burst_write,
  input  logic [WAIT_W-1:0] cfg_trcd,
  input  logic [WAIT_W-1:0] cfg_trp,
  input  logic [WAIT_W-1:0] cfg_trfc,
  input  logic [2:0]        cfg_cl,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_autopre,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_addr,
  input  logic              sleep_req,
  output logic              req_ready,
  output logic              rd_valid,
  output logic              sd_cke,
  output logic              sd_cs2_n,
  output logic              sd_cs3_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [12:0]       sd_addr,
  output logic [1:0]        sd_ba,
  output logic [3:0]        sd_dqm_n
);
  localparam int WW  = WAIT_W + 1;
  localparam int RCW = $clog2(REF_PERIOD + 1);
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100;
  localparam logic [2:0] C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000;

  typedef enum logic [3:0] {
    S_IPALL, S_IREF1, S_IREF2, S_IMRS, S_IDLE, S_RW, S_PRE, S_RREF, S_SENTER, S_SHOLD
  } st_t;

  st_t            state;
  logic [WW-1:0]  wcnt;
  logic [RCW-1:0] ref_cnt;
  logic           ref_pend;
  logic [7:0]     rd_sr;
  logic [12:0]    r_row;
  logic [9:0]     r_col;
  logic [1:0]     r_bank;
  logic [3:0]     r_en, a_en;
  logic           r_space, r_write, r_auto;

  function automatic logic [WW-1:0] ld(input logic [WW-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  wire [5:0]  off   = cfg_wide ? 6'd2 : 6'd1;
  wire [5:0]  colw  = 6'd8 + ((cfg_col_code == 2'd3) ? 6'd2 : {4'd0, cfg_col_code});
  wire [5:0]  roww  = 6'd11 + ((cfg_row_code == 2'd3) ? 6'd2 : {4'd0, cfg_row_code});
  wire [5:0]  bankw = cfg_four_banks ? 6'd2 : 6'd1;
  wire [9:0]  a_col  = 10'((req_addr >> off) & ((32'd1 << colw) - 32'd1));
  wire [1:0]  a_bank = 2'((req_addr >> (off + colw)) & ((32'd1 << bankw) - 32'd1));
  wire [12:0] a_row  = 13'((req_addr >> (off + colw + bankw)) & ((32'd1 << roww) - 32'd1));
  wire        a_space = cfg_two_spaces ? req_addr[31] : 1'b1;

  always_comb begin
    if (cfg_wide)
      case (req_size)
        2'd0:    a_en = 4'b0001 << req_addr[1:0];
        2'd1:    a_en = req_addr[1] ? 4'b1100 : 4'b0011;
        default: a_en = 4'b1111;
      endcase
    else
      a_en = (req_size == 2'd0) ? (req_addr[0] ? 4'b0010 : 4'b0001) : 4'b0011;
  end

  wire idle_free = (state == S_IDLE) && (wcnt == '0);
  wire rd_issue  = (state == S_RW) && (wcnt == '0) && !r_write;
  assign req_ready = idle_free && !ref_pend && !sleep_req;
  assign rd_valid  = rd_sr[cfg_cl];

  wire [WW-1:0] rw_gap = r_write ? WW'(1) : WW'(cfg_cl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IPALL;
      wcnt <= '0;
      ref_cnt <= '0;
      ref_pend <= 1'b0;
      rd_sr <= '0;
      {r_row, r_col, r_bank, r_en, r_space, r_write, r_auto} <= '0;
      {sd_ras_n, sd_cas_n, sd_we_n} <= C_NOP;
      {sd_cs2_n, sd_cs3_n, sd_cke} <= 3'b111;
      sd_addr <= '0;
      sd_ba <= '0;
      sd_dqm_n <= 4'hF;
    end else begin
      {sd_ras_n, sd_cas_n, sd_we_n} <= C_NOP;
      {sd_cs2_n, sd_cs3_n} <= 2'b11;
      sd_addr <= '0;
      sd_ba <= '0;
      sd_dqm_n <= 4'hF;
      rd_sr <= {rd_sr[6:0], rd_issue};
      if (wcnt != '0) wcnt <= wcnt - 1'b1;
      else case (state)
        S_IPALL, S_IDLE: begin
          if (state == S_IPALL || ref_pend || sleep_req) begin
            {sd_ras_n, sd_cas_n, sd_we_n} <= C_PRE;
            sd_addr[10] <= 1'b1;
            {sd_cs2_n, sd_cs3_n} <= {!cfg_two_spaces, 1'b0};
            wcnt <= ld(WW'(cfg_trp));
            state <= (state == S_IPALL) ? S_IREF1 : (ref_pend ? S_RREF : S_SENTER);
          end else if (req_valid) begin
            {sd_ras_n, sd_cas_n, sd_we_n} <= C_ACT;
            sd_addr <= a_row;
            sd_ba <= a_bank;
            {sd_cs2_n, sd_cs3_n} <= {a_space, !a_space};
            {r_row, r_col, r_bank, r_en} <= {a_row, a_col, a_bank, a_en};
            {r_space, r_write, r_auto} <= {a_space, req_write, req_autopre};
            wcnt <= ld(WW'(cfg_trcd));
            state <= S_RW;
          end
        end
        S_IREF1, S_IREF2, S_RREF: begin
          {sd_ras_n, sd_cas_n, sd_we_n} <= C_REF;
          {sd_cs2_n, sd_cs3_n} <= {!cfg_two_spaces, 1'b0};
          wcnt <= ld(WW'(cfg_trfc));
          if (state == S_RREF) ref_pend <= 1'b0;
          state <= (state == S_IREF1) ? S_IREF2 : (state == S_IREF2) ? S_IMRS : S_IDLE;
        end
        S_IMRS: begin
          {sd_ras_n, sd_cas_n, sd_we_n} <= C_MRS;
          sd_addr <= {3'b000, !cfg_burst_write, 2'b00, cfg_cl, 4'b0000};
          {sd_cs2_n, sd_cs3_n} <= {!cfg_two_spaces, 1'b0};
          wcnt <= WW'(1);
          state <= S_IDLE;
        end
        S_RW: begin
          {sd_ras_n, sd_cas_n, sd_we_n} <= r_write ? C_WR : C_RD;
          sd_addr <= {2'b00, r_auto, r_col};
          sd_ba <= r_bank;
          sd_dqm_n <= ~r_en;
          {sd_cs2_n, sd_cs3_n} <= {r_space, !r_space};
          wcnt <= r_auto ? ld(rw_gap + WW'(cfg_trp)) : ld(rw_gap);
          state <= r_auto ? S_IDLE : S_PRE;
        end
        S_PRE: begin
          {sd_ras_n, sd_cas_n, sd_we_n} <= C_PRE;
          sd_ba <= r_bank;
          {sd_cs2_n, sd_cs3_n} <= {r_space, !r_space};
          wcnt <= ld(WW'(cfg_trp));
          state <= S_IDLE;
        end
        S_SENTER: begin
          {sd_ras_n, sd_cas_n, sd_we_n} <= C_REF;
          {sd_cs2_n, sd_cs3_n} <= {!cfg_two_spaces, 1'b0};
          sd_cke <= 1'b0;
          state <= S_SHOLD;
        end
        S_SHOLD: begin
          if (!sleep_req) begin
            sd_cke <= 1'b1;
            wcnt <= ld(WW'(cfg_trfc));
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (ref_cnt == RCW'(REF_PERIOD - 1)) begin
        ref_cnt <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
module sdram_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_two_spaces,
  input logic [2:0]  cfg_cl,
  input logic        req_ready,
  input logic        sd_cke,
  input logic        sd_cs2_n,
  input logic        sd_cs3_n,
  input logic        sd_ras_n,
  input logic        sd_cas_n,
  input logic        sd_we_n,
  input logic [12:0] sd_addr,
  input logic [1:0]  sd_ba,
  input logic [3:0]  sd_dqm_n
);
  wire [2:0] cmd = {sd_ras_n, sd_cas_n, sd_we_n};

  a_r3_cmd_has_select: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 3'b111) |-> !(sd_cs2_n && sd_cs3_n));

  a_r7_single_space_cs2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_two_spaces |-> sd_cs2_n);

  a_r6_mask_only_on_rw: assert property (@(posedge clk) disable iff (!rst_n)
    !(sd_ras_n && !sd_cas_n) |-> (sd_dqm_n == 4'hF));

  a_r5_rw_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_ras_n && !sd_cas_n) |-> (sd_addr[12:11] == 2'b00));

  a_r2_mode_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b000) |-> (sd_addr[3:0] == 4'd0 && sd_addr[6:4] == cfg_cl && sd_ba == 2'd0));

  a_r12_self_entry_encoding: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_cke) |-> (cmd == 3'b001 && !sd_cs3_n));

  a_r12_no_accept_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cke |-> !req_ready);
endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk i_chk (.*);

// File: tb/test_sdram_cmd_ctrl.sv
module test_sdram_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int REFP = 400;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_row_code = 0, cfg_col_code = 0, req_size = 0;
  logic cfg_four_banks = 1, cfg_wide = 1, cfg_two_spaces = 1, cfg_burst_write = 0;
  logic [3:0] cfg_trcd = 2, cfg_trp = 2, cfg_trfc = 4;
  logic [2:0] cfg_cl = 2;
  logic req_valid = 0, req_write = 0, req_autopre = 0, sleep_req = 0;
  logic [31:0] req_addr = 0;
  logic req_ready, rd_valid, sd_cke, sd_cs2_n, sd_cs3_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [12:0] sd_addr;
  logic [1:0] sd_ba;
  logic [3:0] sd_dqm_n;
  int cyc = 0, nchk = 0, nerr = 0;

  sdram_cmd_ctrl #(.REF_PERIOD(REFP), .WAIT_W(4)) i_sdram_cmd_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  wire [2:0] cmd_w = {sd_ras_n, sd_cas_n, sd_we_n};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int n); return (n == 0) ? 1 : n; endfunction
  function automatic int offb(); return cfg_wide ? 2 : 1; endfunction
  function automatic int colb(); return 8 + ((cfg_col_code == 3) ? 2 : cfg_col_code); endfunction
  function automatic int rowb(); return 11 + ((cfg_row_code == 3) ? 2 : cfg_row_code); endfunction
  function automatic int bnkb(); return cfg_four_banks ? 2 : 1; endfunction
  function automatic int e_col(input logic [31:0] a); return int'((a >> offb()) & ((32'd1 << colb()) - 1)); endfunction
  function automatic int e_bank(input logic [31:0] a); return int'((a >> (offb() + colb())) & ((32'd1 << bnkb()) - 1)); endfunction
  function automatic int e_row(input logic [31:0] a); return int'((a >> (offb() + colb() + bnkb())) & ((32'd1 << rowb()) - 1)); endfunction
  function automatic logic [3:0] e_en(input logic [31:0] a, input logic [1:0] s);
    if (cfg_wide) return (s == 0) ? (4'b0001 << a[1:0]) : (s == 1) ? (a[1] ? 4'b1100 : 4'b0011) : 4'b1111;
    return (s == 0) ? (a[0] ? 4'b0010 : 4'b0001) : 4'b0011;
  endfunction

  task automatic next_cmd(output logic [2:0] c, output int t);
    do @(negedge clk); while (cmd_w == 3'b111);
    c = cmd_w;
    t = cyc;
  endtask

  task automatic check_all_cs(input string tag);
    chk(sd_cs3_n == 0 && sd_cs2_n == !cfg_two_spaces, tag, {sd_cs2_n, sd_cs3_n}, {!cfg_two_spaces, 1'b0});
  endtask

  task automatic do_init();
    logic [2:0] c; int t0, t1, t2, t3;
    logic [12:0] mrs;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(cmd_w == 3'b111 && sd_cke && sd_cs2_n && sd_cs3_n && !req_ready, "R3 reset idle", cmd_w, 7);
    rst_n = 1;
    next_cmd(c, t0);
    chk(c == 3'b010 && sd_addr[10], "R1 init precharge-all", c, 2);
    check_all_cs("R7 init selects");
    next_cmd(c, t1);
    chk(c == 3'b001 && t1 - t0 == eff(cfg_trp), "R1 first refresh gap", t1 - t0, eff(cfg_trp));
    next_cmd(c, t2);
    chk(c == 3'b001 && t2 - t1 == eff(cfg_trfc), "R1 second refresh gap", t2 - t1, eff(cfg_trfc));
    next_cmd(c, t3);
    chk(c == 3'b000 && t3 - t2 == eff(cfg_trfc), "R1 mode write gap", t3 - t2, eff(cfg_trfc));
    mrs = {3'b000, !cfg_burst_write, 2'b00, cfg_cl, 4'b0000};
    chk(sd_addr == mrs && sd_ba == 0, "R2 mode register value", sd_addr, mrs);
    chk(!req_ready, "R1 not ready at mode write", req_ready, 0);
    @(negedge clk);
    chk(req_ready, "R1 ready after mode write", req_ready, 1);
  endtask

  task automatic do_access(input logic [31:0] a, input bit wr, input bit au, input logic [1:0] sz);
    logic [2:0] c; int ta, tr;
    bit sp;
    int row, col, bank;
    logic [3:0] en;
    sp = cfg_two_spaces ? a[31] : 1'b1;
    row = e_row(a); col = e_col(a); bank = e_bank(a); en = e_en(a, sz);
    @(negedge clk);
    req_addr = a; req_write = wr; req_autopre = au; req_size = sz; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    ta = cyc;
    chk(cmd_w == 3'b011, "R3 activate encoding", cmd_w, 3);
    chk(sd_addr == row && sd_ba == bank, "R4 R5 activate row/bank", {sd_ba, sd_addr}, {bank[1:0], row[12:0]});
    chk(sd_cs2_n == sp && sd_cs3_n == !sp, "R7 access select", {sd_cs2_n, sd_cs3_n}, {sp, !sp});
    next_cmd(c, tr);
    chk(c == (wr ? 3'b100 : 3'b101), "R3 read/write encoding", c, wr ? 4 : 5);
    chk(tr - ta == eff(cfg_trcd), "R8 activate-to-command gap", tr - ta, eff(cfg_trcd));
    chk(sd_addr == {2'b00, au, col[9:0]} && sd_ba == bank, "R5 column and precharge flag", sd_addr, {2'b00, au, col[9:0]});
    chk(sd_dqm_n == ~en, "R6 byte mask", sd_dqm_n, ~en);
    if (!wr) begin
      repeat (cfg_cl - 1) @(negedge clk);
      chk(!rd_valid, "R10 rd_valid early", rd_valid, 0);
      @(negedge clk);
      chk(rd_valid, "R10 rd_valid at latency", rd_valid, 1);
    end else begin
      @(negedge clk);
    end
    if (!au) begin
      chk(cmd_w == 3'b010 && !sd_addr[10] && sd_ba == bank, "R9 R8 single-bank precharge", {cmd_w, sd_addr[10]}, 4);
    end
    while (!req_ready) @(negedge clk);
  endtask

  task automatic refresh_and_sleep();
    logic [2:0] c; int t0, t1, ts;
    ts = cyc;
    next_cmd(c, t0);
    chk(c == 3'b010 && sd_addr[10] && t0 - ts <= REFP + 2, "R11 periodic precharge-all", t0 - ts, REFP);
    check_all_cs("R7 refresh selects");
    next_cmd(c, t1);
    chk(c == 3'b001 && sd_cke && t1 - t0 == eff(cfg_trp), "R11 refresh after trp", t1 - t0, eff(cfg_trp));
    while (!req_ready) @(negedge clk);
    sleep_req = 1;
    next_cmd(c, t0);
    chk(c == 3'b010 && sd_addr[10], "R12 precharge before sleep", c, 2);
    next_cmd(c, t1);
    chk(c == 3'b001 && !sd_cke && t1 - t0 == eff(cfg_trp), "R12 self-refresh entry", {c, sd_cke}, 2);
    begin
      bit held = 1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (sd_cke || req_ready) held = 0;
      end
      chk(held, "R12 clock enable held low", held, 1);
    end
    sleep_req = 0;
    @(negedge clk);
    chk(sd_cke, "R12 clock enable restored", sd_cke, 1);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic set_cfg(input int r, input int c, input bit b4, input bit w, input bit two, input bit bw,
                         input int trcd, input int trp, input int trfc, input int cl);
    cfg_row_code = r[1:0]; cfg_col_code = c[1:0]; cfg_four_banks = b4; cfg_wide = w;
    cfg_two_spaces = two; cfg_burst_write = bw; cfg_trcd = trcd[3:0]; cfg_trp = trp[3:0];
    cfg_trfc = trfc[3:0]; cfg_cl = cl[2:0];
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog: got %0d expected 0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: set_cfg(0, 0, 1, 1, 1, 0, 2, 2, 4, 2);
        1: set_cfg(2, 2, 1, 0, 0, 1, 3, 1, 3, 3);
        2: set_cfg(1, 1, 0, 1, 0, 0, 0, 0, 2, 2);
        default: set_cfg(3, 3, 1, 0, 1, 1, 1, 3, 5, 3);
      endcase
      do_init();
      do_access(32'hFFFF_FFFF, 1'b0, 1'b0, 2'd0);
      do_access(32'h0000_0002, 1'b1, 1'b0, 2'd1);
      do_access(32'h8000_0001, 1'b1, 1'b1, 2'd0);
      do_access(32'h7FFF_FFFC, 1'b0, 1'b1, 2'd3);
      for (int n = 0; n < 14; n++)
        do_access($urandom, 1'($urandom), 1'($urandom), 2'($urandom));
      if (k == 0) refresh_and_sleep();
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule